// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block produces memory addresses for indirect accesses from a set of eight pointer slots. Each slot pairs an index pointer with a buffer length and a base value. A separate file of eight modifier registers supplies signed step sizes. When a request arrives, the generator picks one pointer and one step. The step comes either from a selected modifier register or from an immediate operand that arrives with the request. The generator then returns an address one clock later.

In post-modify mode the returned address is the pointer as it stood, and the stepped value is written back into the pointer. In pre-modify mode the returned address is the stepped value, and the pointer is left alone. A nonzero length turns the slot into a circular buffer that occupies the window from base up to base plus length. A stepped value that leaves this window is folded back by one length. A zero length gives plain linear stepping, which wraps only at the address width. The address width is a parameter, so one design can serve a wide data-memory space or a narrower program-memory space.

A configuration port writes and reads every register. The register is chosen by a bank code and a slot number. Writing a base value also loads the pointer of the same slot.

Top module: `cbuf_addr_gen`

## Requirements
- R1: After reset, every register in all four banks reads zero and `addr_valid` is low.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the register chosen by `cfg_bank` (0 = index pointer, 1 = modifier, 2 = length, 3 = base) and `cfg_sel`. The register can be read back combinationally on `cfg_rdata` from the next cycle on.
- R3: Writing a base register (bank 3) also loads the index pointer of the same slot with the written value.
- R4: A post-modify request (`gen_req` high, `gen_pre` low) raises `addr_valid` in the following cycle, with `addr_out` equal to the pointer as it was before the request. The pointer then holds the stepped value.
- R5: A pre-modify request (`gen_pre` high) returns the stepped value on `addr_out` in the following cycle and leaves the pointer unchanged.
- R6: With `gen_use_imm` high, the step is `gen_imm` and the modifier register chosen by `gen_mod_sel` is ignored. With it low, the step is that modifier register. Steps are signed two's complement of the address width.
- R7: With a nonzero length, a stepped value at or above base plus length has the length subtracted. Reaching base plus length exactly counts as leaving the window.
- R8: With a nonzero length, a stepped value below base has the length added.
- R9: With a zero length, the stepped value is pointer plus step modulo 2^AW, with no folding.
- R10: When a configuration write to the index or base bank targets the same slot as a post-modify write-back in the same cycle, the configuration value is what the pointer holds afterwards.
- R11: In a cycle without `gen_req`, `addr_valid` goes low the next cycle, `addr_out` keeps its value, and no pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gen_req | input | 1 | Address request |
| gen_pre | input | 1 | 1 = pre-modify, 0 = post-modify |
| gen_ptr_sel | input | 3 | Slot whose pointer, length and base are used |
| gen_mod_sel | input | 3 | Modifier register used when no immediate |
| gen_use_imm | input | 1 | Take the step from gen_imm |
| gen_imm | input | AW | Immediate signed step |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 2 | Register bank: 0 index, 1 modifier, 2 length, 3 base |
| cfg_sel | input | 3 | Register slot for configuration access |
| cfg_wdata | input | AW | Configuration write data |
| cfg_rdata | output | AW | Combinational read of the chosen register |
| addr_valid | output | 1 | addr_out carries a new address this cycle |
| addr_out | output | AW | Generated address |

## Verification
On every cycle, the assertions check four things. They check the one-cycle request-to-valid timing and the idle hold of the output. They check that a post-modify returns the old pointer and that a pre-modify leaves the pointer alone. They check that configuration writes win over write-back. They also check that a pointer inside its window, stepped by no more than the length, lands back inside the window. Only the bench scenarios can show the exact folded values at both window edges, the immediate-versus-register step choice, linear wrap at the top of the address space, the zero state after reset, and the base-to-pointer load.

// File: rtl/cbag_pkg.sv
package cbag_pkg;

  // Register bank codes for the configuration port
  typedef enum logic [1:0] {
    BANK_IDX  = 2'd0,
    BANK_MOD  = 2'd1,
    BANK_LEN  = 2'd2,
    BANK_BASE = 2'd3
  } cbag_bank_e;

endpackage

// File: rtl/cbag_regfile.sv
module cbag_regfile
  import cbag_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NSLOT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_bank,
  input  logic [$clog2(NSLOT)-1:0] cfg_sel,
  input  logic [AW-1:0]            cfg_wdata,
  input  logic                     wb_en,
  input  logic [$clog2(NSLOT)-1:0] wb_sel,
  input  logic [AW-1:0]            wb_data,
  input  logic [$clog2(NSLOT)-1:0] rd_sel,
  input  logic [$clog2(NSLOT)-1:0] rd_mod_sel,
  output logic [AW-1:0]            cfg_rdata,
  output logic [AW-1:0]            ptr_rd,
  output logic [AW-1:0]            mod_rd,
  output logic [AW-1:0]            len_rd,
  output logic [AW-1:0]            base_rd,
  output logic [AW-1:0]            idx_q [NSLOT]
);

  localparam int SELW = $clog2(NSLOT);

  cbag_bank_e bank;
  assign bank = cbag_bank_e'(cfg_bank);

  logic [AW-1:0] mod_q  [NSLOT];
  logic [AW-1:0] len_q  [NSLOT];
  logic [AW-1:0] base_q [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic          hit;
    logic          idx_en, mod_en, len_en, base_en;
    logic [AW-1:0] idx_d;
    logic [AW-1:0] idx_r, mod_r, len_r, base_r;

    assign hit = cfg_we && (cfg_sel == SELW'(i));

    // Next-state: configuration access outranks pointer write-back
    always_comb begin
      idx_en = 1'b0;
      idx_d  = idx_r;
      if (hit && (bank == BANK_IDX || bank == BANK_BASE)) begin
        idx_en = 1'b1;
        idx_d  = cfg_wdata;
      end else if (wb_en && (wb_sel == SELW'(i))) begin
        idx_en = 1'b1;
        idx_d  = wb_data;
      end
    end

    always_comb begin
      mod_en  = hit && (bank == BANK_MOD);
      len_en  = hit && (bank == BANK_LEN);
      base_en = hit && (bank == BANK_BASE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx_r <= '0;
      end else if (idx_en) begin
        idx_r <= idx_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mod_r <= '0;
      end else if (mod_en) begin
        mod_r <= cfg_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_r <= '0;
      end else if (len_en) begin
        len_r <= cfg_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_r <= '0;
      end else if (base_en) begin
        base_r <= cfg_wdata;
      end
    end

    assign idx_q[i]  = idx_r;
    assign mod_q[i]  = mod_r;
    assign len_q[i]  = len_r;
    assign base_q[i] = base_r;
  end

  // Read multiplexers for the address path
  assign ptr_rd  = idx_q[rd_sel];
  assign len_rd  = len_q[rd_sel];
  assign base_rd = base_q[rd_sel];
  assign mod_rd  = mod_q[rd_mod_sel];

  // Configuration read-back
  always_comb begin
    unique case (bank)
      BANK_IDX:  cfg_rdata = idx_q[cfg_sel];
      BANK_MOD:  cfg_rdata = mod_q[cfg_sel];
      BANK_LEN:  cfg_rdata = len_q[cfg_sel];
      BANK_BASE: cfg_rdata = base_q[cfg_sel];
      default:   cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/cbag_wrap.sv
module cbag_wrap #(
  parameter int AW = 32
) (
  input  logic [AW-1:0]        ptr,
  input  logic [AW-1:0]        step,
  input  logic [AW-1:0]        len,
  input  logic [AW-1:0]        base,
  output logic signed [AW+1:0] upd_full
);

  localparam int SW = AW + 2;

  logic signed [SW-1:0] sum_x, lo_x, hi_x, len_x;
  logic                 circ;

  always_comb begin
    sum_x = $signed({2'b00, ptr}) + $signed({{2{step[AW-1]}}, step});
    len_x = $signed({2'b00, len});
    lo_x  = $signed({2'b00, base});
    hi_x  = lo_x + len_x;
    circ  = (len != '0);
  end

  // Fold back by one buffer length when leaving the window
  always_comb begin
    if (circ && (sum_x >= hi_x)) begin
      upd_full = sum_x - len_x;
    end else if (circ && (sum_x < lo_x)) begin
      upd_full = sum_x + len_x;
    end else begin
      upd_full = sum_x;
    end
  end

endmodule

// File: rtl/cbag_ctrl.sv
module cbag_ctrl #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gen_req,
  input  logic          gen_pre,
  input  logic          gen_use_imm,
  input  logic [AW-1:0] gen_imm,
  input  logic [AW-1:0] mod_rd,
  input  logic [AW-1:0] ptr_rd,
  input  logic [AW-1:0] upd,
  output logic [AW-1:0] eff_mod,
  output logic          wb_en,
  output logic [AW-1:0] wb_data,
  output logic          addr_valid,
  output logic [AW-1:0] addr_out
);

  logic [AW-1:0] addr_d, addr_q;
  logic          vld_d, vld_q;
  logic          addr_en;

  assign eff_mod = gen_use_imm ? gen_imm : mod_rd;
  assign wb_en   = gen_req && !gen_pre;
  assign wb_data = upd;

  always_comb begin
    addr_en = gen_req;
    addr_d  = gen_pre ? upd : ptr_rd;
    vld_d   = gen_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  assign addr_valid = vld_q;
  assign addr_out   = addr_q;

endmodule

// File: rtl/cbuf_addr_gen.sv
module cbuf_addr_gen #(
  parameter int AW    = 32,
  parameter int NSLOT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     gen_req,
  input  logic                     gen_pre,
  input  logic [$clog2(NSLOT)-1:0] gen_ptr_sel,
  input  logic [$clog2(NSLOT)-1:0] gen_mod_sel,
  input  logic                     gen_use_imm,
  input  logic [AW-1:0]            gen_imm,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_bank,
  input  logic [$clog2(NSLOT)-1:0] cfg_sel,
  input  logic [AW-1:0]            cfg_wdata,
  output logic [AW-1:0]            cfg_rdata,
  output logic                     addr_valid,
  output logic [AW-1:0]            addr_out
);

  localparam int SELW = $clog2(NSLOT);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync[1];

  logic [AW-1:0]        sel_ptr, sel_mod, sel_len, sel_base;
  logic [AW-1:0]        eff_mod, upd, wb_data;
  logic signed [AW+1:0] upd_full;
  logic                 wb_en;
  logic [AW-1:0]        idx_q [NSLOT];
  logic [SELW-1:0]      wb_sel;

  assign wb_sel = gen_ptr_sel;
  assign upd    = upd_full[AW-1:0];

  cbag_regfile #(.AW(AW), .NSLOT(NSLOT)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg_we     (cfg_we),
    .cfg_bank   (cfg_bank),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .wb_en      (wb_en),
    .wb_sel     (wb_sel),
    .wb_data    (wb_data),
    .rd_sel     (gen_ptr_sel),
    .rd_mod_sel (gen_mod_sel),
    .cfg_rdata  (cfg_rdata),
    .ptr_rd     (sel_ptr),
    .mod_rd     (sel_mod),
    .len_rd     (sel_len),
    .base_rd    (sel_base),
    .idx_q      (idx_q)
  );

  cbag_wrap #(.AW(AW)) u_wrap (
    .ptr      (sel_ptr),
    .step     (eff_mod),
    .len      (sel_len),
    .base     (sel_base),
    .upd_full (upd_full)
  );

  cbag_ctrl #(.AW(AW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .gen_req     (gen_req),
    .gen_pre     (gen_pre),
    .gen_use_imm (gen_use_imm),
    .gen_imm     (gen_imm),
    .mod_rd      (sel_mod),
    .ptr_rd      (sel_ptr),
    .upd         (upd),
    .eff_mod     (eff_mod),
    .wb_en       (wb_en),
    .wb_data     (wb_data),
    .addr_valid  (addr_valid),
    .addr_out    (addr_out)
  );

endmodule

// File: rtl/cbag_checker.sv
module cbag_checker #(
  parameter int AW    = 32,
  parameter int NSLOT = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     gen_req,
  input logic                     gen_pre,
  input logic [$clog2(NSLOT)-1:0] gen_ptr_sel,
  input logic                     cfg_we,
  input logic [1:0]               cfg_bank,
  input logic [$clog2(NSLOT)-1:0] cfg_sel,
  input logic [AW-1:0]            cfg_wdata,
  input logic                     addr_valid,
  input logic [AW-1:0]            addr_out,
  input logic [AW-1:0]            idx_q [NSLOT],
  input logic [AW-1:0]            sel_ptr,
  input logic [AW-1:0]            sel_len,
  input logic [AW-1:0]            sel_base,
  input logic [AW-1:0]            eff_mod,
  input logic signed [AW+1:0]     upd_full
);

  logic signed [AW+1:0] b_x, e_x, p_x, m_x, m_abs, l_x;
  logic                 in_win;

  always_comb begin
    b_x    = $signed({2'b00, sel_base});
    l_x    = $signed({2'b00, sel_len});
    e_x    = b_x + l_x;
    p_x    = $signed({2'b00, sel_ptr});
    m_x    = $signed({{2{eff_mod[AW-1]}}, eff_mod});
    m_abs  = (m_x < 0) ? -m_x : m_x;
    in_win = (sel_len != '0) && (p_x >= b_x) && (p_x < e_x) && (m_abs <= l_x);
  end

  // R4: valid one cycle after request, post-modify returns old pointer
  a_r4_post_old_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_req && !gen_pre) |=> (addr_valid && addr_out == $past(sel_ptr)));

  // R5: pre-modify leaves the pointer alone (absent a config write)
  a_r5_pre_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_req && gen_pre && !cfg_we) |=> (idx_q[$past(gen_ptr_sel)] == $past(sel_ptr)));

  // R7 / R8: a legal step from inside the window lands inside the window
  a_r7_wrap_window: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |-> (upd_full >= b_x && upd_full < e_x));

  // R10: configuration write to index or base wins
  a_r10_cfg_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_bank == 2'd0 || cfg_bank == 2'd3))
      |=> (idx_q[$past(cfg_sel)] == $past(cfg_wdata)));

  // R11: idle cycle drops valid and holds the address
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_req |=> (!addr_valid && $stable(addr_out)));

endmodule

bind cbuf_addr_gen cbag_checker #(.AW(AW), .NSLOT(NSLOT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .gen_req     (gen_req),
  .gen_pre     (gen_pre),
  .gen_ptr_sel (gen_ptr_sel),
  .cfg_we      (cfg_we),
  .cfg_bank    (cfg_bank),
  .cfg_sel     (cfg_sel),
  .cfg_wdata   (cfg_wdata),
  .addr_valid  (addr_valid),
  .addr_out    (addr_out),
  .idx_q       (idx_q),
  .sel_ptr     (sel_ptr),
  .sel_len     (sel_len),
  .sel_base    (sel_base),
  .eff_mod     (eff_mod),
  .upd_full    (upd_full)
);

// File: tb/test_cbuf_addr_gen.sv
`timescale 1ns/1ps
module test_cbuf_addr_gen;

  localparam int AW = 32;

  logic          clk;
  logic          rst_n;
  logic          gen_req, gen_pre, gen_use_imm;
  logic [2:0]    gen_ptr_sel, gen_mod_sel;
  logic [AW-1:0] gen_imm;
  logic          cfg_we;
  logic [1:0]    cfg_bank;
  logic [2:0]    cfg_sel;
  logic [AW-1:0] cfg_wdata;
  logic [AW-1:0] cfg_rdata;
  logic          addr_valid;
  logic [AW-1:0] addr_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  cbuf_addr_gen #(.AW(AW), .NSLOT(8)) i_cbuf_addr_gen (
    .clk, .rst_n, .gen_req, .gen_pre, .gen_ptr_sel, .gen_mod_sel,
    .gen_use_imm, .gen_imm, .cfg_we, .cfg_bank, .cfg_sel, .cfg_wdata,
    .cfg_rdata, .addr_valid, .addr_out
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [2:0]  ps;
    logic [2:0]  ms;
    logic        ie;
    logic [31:0] imm;
    logic        pre;
    logic [31:0] ea;
    logic [31:0] ep;
  } vec_t;

  // slot0: base 100 len 10, mod0 = 3 ; slot1: base 0x200 len 0, mod1 = -4
  localparam vec_t VEC [9] = '{
    '{3'd0, 3'd0, 1'b0, 32'd0,          1'b0, 32'd100,   32'd103},   // R4
    '{3'd0, 3'd0, 1'b0, 32'd0,          1'b0, 32'd103,   32'd106},
    '{3'd0, 3'd0, 1'b0, 32'd0,          1'b0, 32'd106,   32'd109},
    '{3'd0, 3'd0, 1'b0, 32'd0,          1'b0, 32'd109,   32'd102},   // R7
    '{3'd0, 3'd0, 1'b0, 32'd0,          1'b1, 32'd105,   32'd102},   // R5
    '{3'd0, 3'd0, 1'b1, 32'hFFFFFFFB,   1'b0, 32'd102,   32'd107},   // R6 R8
    '{3'd0, 3'd0, 1'b1, 32'hFFFFFFFB,   1'b1, 32'd102,   32'd107},   // R5 R6
    '{3'd1, 3'd1, 1'b0, 32'd0,          1'b0, 32'h200,   32'h1FC},   // R9
    '{3'd1, 3'd1, 1'b1, 32'h1000,       1'b1, 32'h11FC,  32'h1FC}    // R6 R9
  };

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] b, input logic [2:0] s, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = b; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [AW-1:0] rd(input logic [1:0] b, input logic [2:0] s);
    cfg_bank = b; cfg_sel = s;
    return cfg_rdata;
  endfunction

  task automatic read_reg(input logic [1:0] b, input logic [2:0] s, output logic [AW-1:0] v);
    cfg_bank = b; cfg_sel = s;
    #1 v = cfg_rdata;
  endtask

  task automatic gen(input logic [2:0] ps, input logic [2:0] ms, input logic ie,
                     input logic [AW-1:0] imm, input logic pre);
    @(negedge clk);
    gen_req = 1'b1; gen_ptr_sel = ps; gen_mod_sel = ms;
    gen_use_imm = ie; gen_imm = imm; gen_pre = pre;
    @(negedge clk);
    gen_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] v;
    logic [AW-1:0] hold;
    rst_n = 1'b0; gen_req = 1'b0; gen_pre = 1'b0; gen_use_imm = 1'b0;
    gen_ptr_sel = '0; gen_mod_sel = '0; gen_imm = '0;
    cfg_we = 1'b0; cfg_bank = '0; cfg_sel = '0; cfg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 valid", {31'd0, addr_valid}, '0);
    for (int b = 0; b < 4; b++) begin
      for (int s = 0; s < 8; s++) begin
        read_reg(2'(b), 3'(s), v);
        check("R1 reg", v, '0);
      end
    end

    // R2 / R3: configuration
    cfg_write(2'd3, 3'd0, 32'd100);
    read_reg(2'd0, 3'd0, v); check("R3 base loads index", v, 32'd100);
    read_reg(2'd3, 3'd0, v); check("R2 base readback", v, 32'd100);
    cfg_write(2'd2, 3'd0, 32'd10);
    cfg_write(2'd1, 3'd0, 32'd3);
    read_reg(2'd2, 3'd0, v); check("R2 length readback", v, 32'd10);
    read_reg(2'd1, 3'd0, v); check("R2 modifier readback", v, 32'd3);
    cfg_write(2'd3, 3'd1, 32'h200);
    cfg_write(2'd1, 3'd1, 32'hFFFFFFFC);
    read_reg(2'd0, 3'd1, v); check("R3 base loads index slot1", v, 32'h200);

    // Vector table walk
    for (int k = 0; k < 9; k++) begin
      gen(VEC[k].ps, VEC[k].ms, VEC[k].ie, VEC[k].imm, VEC[k].pre);
      check("R4 valid after request", {31'd0, addr_valid}, 32'd1);
      check(VEC[k].pre ? "R5 pre address" : "R4 post address", addr_out, VEC[k].ea);
      read_reg(2'd0, VEC[k].ps, v);
      check(VEC[k].pre ? "R5 pointer unchanged" : "R7 R8 pointer update", v, VEC[k].ep);
    end

    // R9: linear wrap at the top of the address space (slot2, len 0, ptr 0)
    gen(3'd2, 3'd0, 1'b1, 32'hFFFFFFFF, 1'b1);
    check("R9 pre wrap address", addr_out, 32'hFFFFFFFF);
    gen(3'd2, 3'd0, 1'b1, 32'hFFFFFFFF, 1'b0);
    check("R9 post address", addr_out, 32'd0);
    read_reg(2'd0, 3'd2, v); check("R9 pointer wraps", v, 32'hFFFFFFFF);

    // R7 exact upper edge, R8 exact lower edge: slot4 base 20 len 4
    cfg_write(2'd3, 3'd4, 32'd20);
    cfg_write(2'd2, 3'd4, 32'd4);
    gen(3'd4, 3'd0, 1'b1, 32'd4, 1'b0);
    read_reg(2'd0, 3'd4, v); check("R7 equal to end folds", v, 32'd20);
    gen(3'd4, 3'd0, 1'b1, 32'hFFFFFFFF, 1'b0);
    read_reg(2'd0, 3'd4, v); check("R8 below base folds", v, 32'd23);

    // R6: modifier register ignored when immediate selected (mod0 = 3)
    gen(3'd4, 3'd0, 1'b1, 32'd0, 1'b1);
    check("R6 immediate zero step", addr_out, 32'd23);

    // R10: config write and write-back on the same slot in one cycle
    cfg_write(2'd3, 3'd3, 32'd50);
    @(negedge clk);
    gen_req = 1'b1; gen_ptr_sel = 3'd3; gen_use_imm = 1'b1; gen_imm = 32'd5; gen_pre = 1'b0;
    cfg_we = 1'b1; cfg_bank = 2'd0; cfg_sel = 3'd3; cfg_wdata = 32'd77;
    @(negedge clk);
    gen_req = 1'b0; cfg_we = 1'b0;
    check("R10 address is old pointer", addr_out, 32'd50);
    read_reg(2'd0, 3'd3, v); check("R10 config wins", v, 32'd77);

    // R11: idle cycle
    hold = addr_out;
    @(negedge clk);
    check("R11 valid low", {31'd0, addr_valid}, '0);
    check("R11 address held", addr_out, hold);
    read_reg(2'd0, 3'd3, v); check("R11 pointer unchanged", v, 32'd77);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule